// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small 8-bit processor core. Each cycle the decoder may present one operation, two operands and a valid strobe. Unary operations work on the first operand. The block registers the 8-bit result together with a writeback enable for the register file, and it keeps the 8-bit status byte in its own register.

Every operation has a fixed set of status flags that it may change. The remaining flags keep their old value. The set covers add and subtract, each with and without carry in, and compare, which subtracts without writing back. It also covers AND, OR and XOR, one's and two's complement, increment, decrement, and loading all ones. The immediate and bit-set/bit-clear forms of instructions reuse these codes, with the constant driven on the second operand. The interrupt-enable and bit-copy flags are never touched by an operation. The core changes them, or restores a saved status byte, through a direct status load.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `result` is 0x00, `result_we` is 0 and `sreg` is 0x00.
- R2: An operation presented with `op_valid` high shows in `result`, `result_we` and `sreg` one clock later. In a cycle with `op_valid` and `sreg_wr` both low, `result_we` is 0 on the next cycle and `result` and `sreg` hold.
- R3: `sreg` bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. ADD (op_sel 0) computes a+b and ADC (op_sel 1) computes a+b+C. Both write back and update H (carry out of bit 3), S, V (signed overflow), N (bit 7), Z (result zero) and C (carry out of bit 7). I and T hold.
- R4: SUB (op_sel 2) computes a-b and SBC (op_sel 3) computes a-b-C. Both write back. C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow. For SBC, Z is 1 only if the result is zero and Z was already 1.
- R5: CMP (op_sel 4) and CPC (op_sel 5) set the flags exactly as SUB and SBC do, including the Z chaining of CPC. `result_we` is 0 and `result` keeps its previous value.
- R6: AND (op_sel 6), OR (op_sel 7) and XOR (op_sel 8) of a and b write back, update Z and N, clear V, set S equal to N, and hold C and H.
- R7: One's complement (op_sel 9) writes back 0xFF-a, sets C to 1, clears V, updates Z, N and S, and holds H.
- R8: Two's complement (op_sel 10) writes back 0x00-a. C is 1 when a is not zero, V is 1 when a is 0x80, H is the borrow into bit 4, and Z, N and S are updated.
- R9: Increment (op_sel 11) and decrement (op_sel 12) write back a+1 and a-1. V is set only when crossing from 0x7F to 0x80 or from 0x80 to 0x7F. Z, N and S are updated, and C and H hold.
- R10: Set (op_sel 13) writes back 0xFF and changes no flag. Codes 14 and 15 write nothing back and change no flag. No operation ever changes a flag outside its own set.
- R11: Whenever an operation updates N or V, S becomes N XOR V. I and T change only through a status load.
- R12: With `sreg_wr` high, `sreg` takes `sreg_wdata` on the next clock, even if an operation is presented in the same cycle. That operation still writes back its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opa | input | 8 | First operand, the destination register value |
| opb | input | 8 | Second operand, a register value or an immediate |
| sreg_wr | input | 1 | Load the status byte directly |
| sreg_wdata | input | 8 | Status byte to load |
| result | output | 8 | Registered result |
| result_we | output | 1 | Registered writeback enable for `result` |
| sreg | output | 8 | Status register |

## Verification
Each result of this block is due exactly one rising edge after its stimulus: the written-back value, its enable and every flag of the status byte. A status load is due on the same edge. The bench changes inputs on a falling edge and withdraws them on the next falling edge. Between those two falling edges lies the single rising edge that captures them, and all three outputs are compared at that second falling edge. Holds are checked the same way: after idle cycles, after compares and after the reserved codes, the bench compares `result` and `sreg` with the values it last expected, not only `result_we`.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_Z = 1;
  localparam int unsigned FB_N = 2;
  localparam int unsigned FB_V = 3;
  localparam int unsigned FB_S = 4;
  localparam int unsigned FB_H = 5;
  localparam int unsigned FB_T = 6;
  localparam int unsigned FB_I = 7;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_CPC = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_COM = 4'd9,
    OP_NEG = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12,
    OP_SET = 4'd13,
    OP_R14 = 4'd14,
    OP_R15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LK_AND = 2'd0,
    LK_OR  = 2'd1,
    LK_XOR = 2'd2,
    LK_NOT = 2'd3
  } logic_kind_e;

  // Flags each operation is allowed to change.
  function automatic logic [7:0] flag_set(input alu_op_e op);
    logic [7:0] m;
    m = 8'h00;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
        m[FB_H] = 1'b1; m[FB_S] = 1'b1; m[FB_V] = 1'b1;
        m[FB_N] = 1'b1; m[FB_Z] = 1'b1; m[FB_C] = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        m[FB_S] = 1'b1; m[FB_V] = 1'b1; m[FB_N] = 1'b1; m[FB_Z] = 1'b1;
      end
      OP_COM: begin
        m[FB_S] = 1'b1; m[FB_V] = 1'b1; m[FB_N] = 1'b1;
        m[FB_Z] = 1'b1; m[FB_C] = 1'b1;
      end
      default: m = 8'h00;
    endcase
    return m;
  endfunction

  function automatic logic writes_back(input alu_op_e op);
    case (op)
      OP_CMP, OP_CPC, OP_R14, OP_R15: return 1'b0;
      default:                        return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  logic [W:0]  wide;
  logic [HB:0] nib;

  always_comb begin
    if (sub) begin
      wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      nib  = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      nib  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
    end
  end

  assign sum   = wide[W-1:0];
  assign c_out = wide[W];
  assign h_out = nib[HB];

  always_comb begin
    if (sub)
      v_out = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
    else
      v_out = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_kind_e  kind,
  output logic [W-1:0] y
);
  always_comb begin
    case (kind)
      LK_AND:  y = a & b;
      LK_OR:   y = a | b;
      LK_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_fire,
  input  logic [SW-1:0] upd_mask,
  input  logic [SW-1:0] cand,
  input  logic          ld,
  input  logic [SW-1:0] ld_data,
  output logic [SW-1:0] sreg_q
);
  always_ff @(posedge clk) begin
    if (rst)
      sreg_q <= '0;
    else if (ld)
      sreg_q <= ld_data;
    else if (op_fire)
      sreg_q <= (cand & upd_mask) | (sreg_q & ~upd_mask);
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld |=> sreg_q == $past(ld_data)); // R12

  AST_OUTSIDE_SET_HELD: assert property (@(posedge clk) disable iff (rst)
    (op_fire && !ld) |=> ((sreg_q ^ $past(sreg_q)) & ~$past(upd_mask)) == '0); // R10

  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!op_fire && !ld) |=> $stable(sreg_q)); // R2

  AST_IT_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(sreg_q[SW-1:SW-2])); // R11

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sreg_wr,
  input  logic [7:0]   sreg_wdata,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [7:0]   sreg
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  alu_op_e     op;
  logic [W-1:0] ar_a, ar_b, ar_sum, lg_y, res;
  logic         ar_cin, ar_sub, ar_c, ar_h, ar_v;
  logic_kind_e  lg_kind;
  logic         is_arith, is_logic, z_chain, z_raw;
  logic [7:0]   cand, mask;

  assign op = alu_op_e'(op_sel);

  // Operand steering onto the shared adder/subtractor.
  always_comb begin
    ar_a     = opa;
    ar_b     = opb;
    ar_cin   = 1'b0;
    ar_sub   = 1'b0;
    is_arith = 1'b1;
    case (op)
      OP_ADD: ;
      OP_ADC: ar_cin = sreg[FB_C];
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SBC, OP_CPC: begin ar_sub = 1'b1; ar_cin = sreg[FB_C]; end
      OP_NEG: begin ar_a = '0; ar_b = opa; ar_sub = 1'b1; end
      OP_INC: ar_b = ONE;
      OP_DEC: begin ar_b = ONE; ar_sub = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  always_comb begin
    lg_kind  = LK_NOT;
    is_logic = 1'b1;
    case (op)
      OP_AND:  lg_kind = LK_AND;
      OP_OR:   lg_kind = LK_OR;
      OP_XOR:  lg_kind = LK_XOR;
      OP_COM:  lg_kind = LK_NOT;
      default: is_logic = 1'b0;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_sum), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .kind(lg_kind), .y(lg_y)
  );

  always_comb begin
    if (is_arith)       res = ar_sum;
    else if (is_logic)  res = lg_y;
    else if (op == OP_SET) res = ONES;
    else                res = '0;
  end

  // Candidate flags; the status unit keeps only those in the op's set.
  assign z_chain = (op == OP_SBC) || (op == OP_CPC);
  assign z_raw   = (res == '0);

  always_comb begin
    cand        = sreg;
    cand[FB_C]  = (op == OP_COM) ? 1'b1 : ar_c;
    cand[FB_V]  = is_logic ? 1'b0 : ar_v;
    cand[FB_H]  = ar_h;
    cand[FB_N]  = res[W-1];
    cand[FB_Z]  = z_chain ? (z_raw & sreg[FB_Z]) : z_raw;
    cand[FB_S]  = cand[FB_N] ^ cand[FB_V];
  end

  assign mask = flag_set(op);

  alu8_status #(.SW(8)) u_status (
    .clk(clk), .rst(rst), .op_fire(op_valid), .upd_mask(mask), .cand(cand),
    .ld(sreg_wr), .ld_data(sreg_wdata), .sreg_q(sreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
    end else begin
      result_we <= op_valid && writes_back(op);
      if (op_valid && writes_back(op))
        result <= res;
    end
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == 4'd4 || op_sel == 4'd5)) |=> (!result_we && $stable(result))); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!result_we && $stable(result))); // R2

  AST_COM_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sreg_wr && op_sel == 4'd9) |=> sreg[FB_C]); // R7

  AST_SET_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 4'd13) |=> (result_we && result == ONES)); // R10

  AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sreg_wr && mask[FB_V]) |=> (sreg[FB_S] == (sreg[FB_N] ^ sreg[FB_V]))); // R11

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic       sreg_wr = 1'b0;
  logic [7:0] sreg_wdata = 8'h00;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] sreg;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] m_res  = 8'h00;
  logic [7:0] m_sreg = 8'h00;

  always #5 clk = ~clk;

  alu8_core #(.W(8)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .sreg_wr(sreg_wr), .sreg_wdata(sreg_wdata),
    .result(result), .result_we(result_we), .sreg(sreg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // Expected behaviour, written from the requirements.
  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] s, output logic [7:0] r, output logic we,
                                output logic [7:0] so);
    int x, y, ci, t, tn, ts;
    bit c, h, v;
    so = s; we = 1'b1; r = 8'h00;
    case (op)
      4'd0, 4'd1, 4'd11: begin
        x = int'(a); y = (op == 4'd11) ? 1 : int'(b);
        ci = (op == 4'd1) ? int'(s[0]) : 0;
        t = x + y + ci; tn = (x % 16) + (y % 16) + ci;
        ts = sx(a) + ((op == 4'd11) ? 1 : sx(b)) + ci;
        r = t[7:0]; c = t > 255; h = tn > 15; v = (ts > 127) || (ts < -128);
        if (op != 4'd11) begin so[5] = h; so[0] = c; end
        so[3] = v;
      end
      4'd2, 4'd3, 4'd4, 4'd5, 4'd10, 4'd12: begin
        if (op == 4'd10) begin x = 0; y = int'(a); end
        else begin x = int'(a); y = (op == 4'd12) ? 1 : int'(b); end
        ci = (op == 4'd3 || op == 4'd5) ? int'(s[0]) : 0;
        t = x - y - ci; tn = (x % 16) - (y % 16) - ci;
        ts = ((op == 4'd10) ? 0 : sx(a)) - ((op == 4'd10) ? sx(a) : ((op == 4'd12) ? 1 : sx(b))) - ci;
        r = t[7:0]; c = t < 0; h = tn < 0; v = (ts > 127) || (ts < -128);
        if (op != 4'd12) begin so[5] = h; so[0] = c; end
        so[3] = v;
        if (op == 4'd4 || op == 4'd5) we = 1'b0;
      end
      4'd6: begin r = a & b; so[3] = 1'b0; end
      4'd7: begin r = a | b; so[3] = 1'b0; end
      4'd8: begin r = a ^ b; so[3] = 1'b0; end
      4'd9: begin r = 8'hFF - a; so[3] = 1'b0; so[0] = 1'b1; end
      4'd13: r = 8'hFF;
      default: we = 1'b0;
    endcase
    if (op <= 4'd12) begin
      so[2] = r[7];
      so[1] = (op == 4'd3 || op == 4'd5) ? ((r == 8'h00) && s[1]) : (r == 8'h00);
      so[4] = so[2] ^ so[3];
    end
    if (!we) r = 8'h00;
  endfunction

  // Present one operation (optionally with a status load) and check it one edge later.
  task automatic do_op(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input bit ld = 1'b0, input logic [7:0] ldv = 8'h00);
    logic [7:0] er, es;
    logic ew;
    model(op, a, b, m_sreg, er, ew, es);
    if (ew) m_res = er;
    m_sreg = ld ? ldv : es;
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; opa = a; opb = b; sreg_wr = ld; sreg_wdata = ldv;
    @(negedge clk);
    op_valid = 1'b0; sreg_wr = 1'b0;
    chk(req, "result", int'(result), int'(m_res));
    chk(req, "result_we", int'(result_we), int'(ew));
    chk(req, "sreg", int'(sreg), int'(m_sreg));
  endtask

  task automatic load_sreg(input string req, input logic [7:0] v);
    @(negedge clk);
    sreg_wr = 1'b1; sreg_wdata = v;
    @(negedge clk);
    sreg_wr = 1'b0;
    m_sreg = v;
    chk(req, "sreg load", int'(sreg), int'(v));
  endtask

  task automatic t_reset();
    chk("R1", "result in reset", int'(result), 0);
    chk("R1", "we in reset", int'(result_we), 0);
    chk("R1", "sreg in reset", int'(sreg), 0);
    @(negedge clk); rst = 1'b0;
    chk("R1", "result after reset", int'(result), 0);
    chk("R1", "sreg after reset", int'(sreg), 0);
  endtask

  task automatic t_add();
    load_sreg("R3", 8'hC0);
    do_op("R3", 4'd0, 8'h0F, 8'h01);
    chk("R3", "H on nibble carry", int'(sreg[5]), 1);
    chk("R3", "I,T kept", int'(sreg[7:6]), 3);
    do_op("R3", 4'd0, 8'h7F, 8'h01);
    chk("R3", "V on 7F+1", int'(sreg[3]), 1);
    do_op("R3", 4'd0, 8'hFF, 8'h01);
    chk("R3", "C and Z on FF+1", int'(sreg[1:0]), 3);
    do_op("R3", 4'd1, 8'h10, 8'h20);
    chk("R3", "ADC adds carry", int'(result), 8'h31);
  endtask

  task automatic t_sub();
    load_sreg("R4", 8'h00);
    do_op("R4", 4'd2, 8'h10, 8'h01);
    chk("R4", "H on nibble borrow", int'(sreg[5]), 1);
    do_op("R4", 4'd2, 8'h00, 8'h01);
    chk("R4", "C on borrow", int'(sreg[0]), 1);
    load_sreg("R4", 8'h01);
    do_op("R4", 4'd3, 8'h01, 8'h00);
    chk("R4", "SBC Z kept clear", int'(sreg[1]), 0);
    load_sreg("R4", 8'h03);
    do_op("R4", 4'd3, 8'h01, 8'h00);
    chk("R4", "SBC Z kept set", int'(sreg[1]), 1);
  endtask

  task automatic t_cmp();
    do_op("R5", 4'd0, 8'h55, 8'h00);
    do_op("R5", 4'd4, 8'h34, 8'h34);
    chk("R5", "result held", int'(result), 8'h55);
    do_op("R5", 4'd5, 8'h12, 8'h12);
    chk("R5", "16-bit equal Z", int'(sreg[1]), 1);
    do_op("R5", 4'd4, 8'h00, 8'h34);
    do_op("R5", 4'd5, 8'h13, 8'h12);
    chk("R5", "chained Z stays clear", int'(sreg[1]), 0);
    chk("R5", "no writeback", int'(result_we), 0);
  endtask

  task automatic t_logic();
    load_sreg("R6", 8'h29);
    do_op("R6", 4'd6, 8'hF0, 8'h0F);
    chk("R6", "AND zero, V clear, C H kept", int'(sreg), 8'h23);
    do_op("R6", 4'd7, 8'h80, 8'h01);
    do_op("R6", 4'd8, 8'hAA, 8'hAA);
  endtask

  task automatic t_com();
    load_sreg("R7", 8'h28);
    do_op("R7", 4'd9, 8'h0F, 8'h00);
    chk("R7", "COM value", int'(result), 8'hF0);
    chk("R7", "C set V clear H kept", int'(sreg[5:0]), 6'h35);
    do_op("R7", 4'd9, 8'hFF, 8'h00);
  endtask

  task automatic t_neg();
    do_op("R8", 4'd10, 8'h80, 8'h00);
    chk("R8", "V on 80", int'(sreg[3]), 1);
    do_op("R8", 4'd10, 8'h00, 8'h00);
    chk("R8", "C clear on 00", int'(sreg[0]), 0);
    do_op("R8", 4'd10, 8'h01, 8'h00);
    chk("R8", "NEG 01", int'(result), 8'hFF);
  endtask

  task automatic t_incdec();
    load_sreg("R9", 8'h21);
    do_op("R9", 4'd11, 8'h7F, 8'h00);
    chk("R9", "INC V", int'(sreg[3]), 1);
    do_op("R9", 4'd12, 8'h80, 8'h00);
    chk("R9", "DEC V", int'(sreg[3]), 1);
    do_op("R9", 4'd11, 8'hFF, 8'h00);
    chk("R9", "C and H held", int'({sreg[5], sreg[0]}), 3);
  endtask

  task automatic t_set_rsv();
    load_sreg("R10", 8'h3F);
    do_op("R10", 4'd13, 8'h00, 8'h00);
    chk("R10", "SET value", int'(result), 8'hFF);
    do_op("R10", 4'd14, 8'h12, 8'h34);
    do_op("R10", 4'd15, 8'h56, 8'h78);
    chk("R10", "reserved keeps flags", int'(sreg), 8'h3F);
  endtask

  task automatic t_sign();
    load_sreg("R11", 8'hC0);
    do_op("R11", 4'd2, 8'h80, 8'h01);
    chk("R11", "S=N^V", int'(sreg[4]), 1);
    chk("R11", "I,T untouched", int'(sreg[7:6]), 3);
  endtask

  task automatic t_load();
    load_sreg("R12", 8'hC1);
    do_op("R12", 4'd0, 8'hFF, 8'h01, 1'b1, 8'h40);
    chk("R12", "load beats op flags", int'(sreg), 8'h40);
    chk("R12", "result still written", int'(result), 8'h00);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_valid = 1'b0; op_sel = 4'd0; opa = 8'hAB; opb = 8'hCD;
    repeat (3) @(negedge clk);
    chk("R2", "idle we", int'(result_we), 0);
    chk("R2", "idle result", int'(result), int'(m_res));
    chk("R2", "idle sreg", int'(sreg), int'(m_sreg));
  endtask

  task automatic t_sweep();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 37 == 0) load_sreg("R11", lf[7:0]);
      do_op("R3", lf[3:0], lf[11:4], lf[15:8] ^ lf[7:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_com();
    t_neg();
    t_incdec();
    t_set_rsv();
    t_sign();
    t_load();
    t_idle();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule